// File: doc/BRIEF.md
# Flag Word and Branch Condition Unit

This block keeps the processor status word of a 16-bit integer core and decides whether a conditional branch is taken. Arithmetic and logic results arrive from the datapath together with their carry, half-carry and overflow side signals. When an update is requested, the block derives the parity, zero and sign bits from the result, honouring a byte or word operand size. Separate commands set, clear or toggle the carry bit and set or clear the interrupt-enable and string-direction bits. A whole-word load replaces every defined bit at once, for example when a saved word is restored from the stack.

The branch evaluator is purely combinational and reads the registered flag word. A 4-bit condition code selects one of eight base tests, and its lowest bit inverts the result. A separate select forces the decision onto a count-register-is-zero input instead. Every update is absorbed in the cycle it is presented, so the result path carries no valid/ready pair and never applies back-pressure. The enables act as plain single-cycle strobes.

Top module: `psw_branch_unit`

## Requirements
- R1: After reset the flag word reads 0x0002.
- R2: Bit 1 of the flag word always reads 1, and bits 3, 5 and 15:12 always read 0, including after a whole-word load that writes other values to them.
- R3: When load_i is high, the next flag word takes bits 0, 2, 4, 6-11 from load_data_i; the load overrides a status update and a command in the same cycle.
- R4: When status_upd_i is high (and no load), bit 0 (carry) takes carry_i, bit 4 (half-carry) takes aux_i and bit 11 (overflow) takes ovf_i on the next edge.
- R5: On a status update, bit 2 (parity) becomes 1 when bits 7:0 of result_i hold an even number of ones, and 0 otherwise, for both operand sizes.
- R6: On a status update with word_i=1, bit 6 (zero) is 1 exactly when all 16 result bits are 0 and bit 7 (sign) takes result bit 15; with word_i=0, the zero bit looks at result bits 7:0 only and the sign bit takes result bit 7.
- R7: ctl_cmd_i encodes 0 none, 1 clear carry, 2 set carry, 3 toggle carry, 4 clear bit 9 (interrupt enable), 5 set bit 9, 6 clear bit 10 (direction), 7 set bit 10; bit 8 (trap) changes only through a whole-word load.
- R8: When a status update and a command arrive in the same cycle, the status update decides the carry bit, while commands 4-7 still take effect.
- R9: With no load, no status update and command 0, the flag word holds its value.
- R10: With count_sel_i=0, condition codes 0-7 test: 0 overflow=1, 1 overflow=0, 2 carry=1, 3 carry=0, 4 zero=1, 5 zero=0, 6 carry or zero, 7 carry=0 and zero=0.
- R11: With count_sel_i=0, condition codes 8-15 test: 8 sign=1, 9 sign=0, 10 parity=1, 11 parity=0, 12 sign xor overflow, 13 sign equals overflow, 14 (sign xor overflow) or zero, 15 zero=0 and sign equals overflow.
- R12: With count_sel_i=1, take_o equals count_zero_i whatever the condition code.
- R13: take_o is evaluated combinationally from the current registered flag word, with no added cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| result_i | input | 16 | Result value from the datapath |
| carry_i | input | 1 | Carry out of the operation |
| aux_i | input | 1 | Half-carry out of bit 3 |
| ovf_i | input | 1 | Signed overflow of the operation |
| word_i | input | 1 | Operand size: 1 word, 0 byte |
| status_upd_i | input | 1 | Update the six status bits from the result |
| ctl_cmd_i | input | 3 | Control-bit command (see R7) |
| load_i | input | 1 | Whole-word load strobe |
| load_data_i | input | 16 | Word to load |
| cond_i | input | 4 | Branch condition code |
| count_sel_i | input | 1 | Select the count-is-zero test |
| count_zero_i | input | 1 | Count register equals zero |
| flags_o | output | 16 | Registered flag word |
| take_o | output | 1 | Branch taken |

## Verification
The bound checker watches on every cycle that the fixed bits keep their values, that loads, status updates and commands land one edge later with the stated priority, that an idle cycle leaves the word untouched, and that the taken output tracks the selected test. The scoreboard bench replays a reference model of the word across byte and word results, parity corners, combined update-and-command cycles and a sweep of all sixteen condition codes over several flag patterns; only those scenarios show that the decoding of each individual condition and of each command value matches the stated encodings.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int FLAG_W    = 16;
  localparam int POS_CARRY = 0;
  localparam int POS_PAR   = 2;
  localparam int POS_AUX   = 4;
  localparam int POS_ZERO  = 6;
  localparam int POS_SIGN  = 7;
  localparam int POS_TRAP  = 8;
  localparam int POS_INTEN = 9;
  localparam int POS_DIR   = 10;
  localparam int POS_OVF   = 11;
  localparam int POS_ONE   = 1;
  localparam int COND_W    = 4;
  localparam int NUM_BASE  = 1 << (COND_W - 1);

  localparam logic [FLAG_W-1:0] FIXED_ONES = FLAG_W'(1) << POS_ONE;
  localparam logic [FLAG_W-1:0] DEF_MASK =
      (FLAG_W'(1) << POS_CARRY) | (FLAG_W'(1) << POS_PAR)   |
      (FLAG_W'(1) << POS_AUX)   | (FLAG_W'(1) << POS_ZERO)  |
      (FLAG_W'(1) << POS_SIGN)  | (FLAG_W'(1) << POS_TRAP)  |
      (FLAG_W'(1) << POS_INTEN) | (FLAG_W'(1) << POS_DIR)   |
      (FLAG_W'(1) << POS_OVF);
  localparam logic [FLAG_W-1:0] RESET_WORD = FIXED_ONES;

  typedef enum logic [2:0] {
    CMD_NONE  = 3'd0,
    CMD_CLR_C = 3'd1,
    CMD_SET_C = 3'd2,
    CMD_TGL_C = 3'd3,
    CMD_CLR_I = 3'd4,
    CMD_SET_I = 3'd5,
    CMD_CLR_D = 3'd6,
    CMD_SET_D = 3'd7
  } ctl_cmd_e;

  typedef struct packed {
    logic carry;
    logic parity;
    logic aux;
    logic zero;
    logic sign;
    logic ovf;
  } status_t;

  function automatic logic [FLAG_W-1:0] fix_word(input logic [FLAG_W-1:0] w);
    return (w & DEF_MASK) | FIXED_ONES;
  endfunction
endpackage

// File: rtl/psw_status_calc.sv
module psw_status_calc
  import psw_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic [DATA_W-1:0] result_i,
  input  logic              carry_i,
  input  logic              aux_i,
  input  logic              ovf_i,
  input  logic              word_i,
  output status_t           status_o
);
  localparam int PAR_W = BYTE_W;

  logic [BYTE_W-1:0] low_byte;
  logic              word_zero;
  logic              byte_zero;
  logic              par_even;

  assign low_byte  = result_i[BYTE_W-1:0];
  assign word_zero = (result_i == '0);
  assign byte_zero = (low_byte == '0);

  // parity tree over the low byte only
  logic [PAR_W:0] par_chain;
  assign par_chain[0] = 1'b0;
  for (genvar i = 0; i < PAR_W; i++) begin : g_par
    assign par_chain[i+1] = par_chain[i] ^ low_byte[i];
  end
  assign par_even = ~par_chain[PAR_W];

  always_comb begin
    status_o.carry  = carry_i;
    status_o.aux    = aux_i;
    status_o.ovf    = ovf_i;
    status_o.parity = par_even;
    if (word_i) begin
      status_o.zero = word_zero;
      status_o.sign = result_i[DATA_W-1];
    end else begin
      status_o.zero = byte_zero;
      status_o.sign = result_i[BYTE_W-1];
    end
  end
endmodule

// File: rtl/psw_word_reg.sv
module psw_word_reg
  import psw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [FLAG_W-1:0] load_data_i,
  input  logic              status_upd_i,
  input  status_t           status_i,
  input  ctl_cmd_e          cmd_i,
  output logic [FLAG_W-1:0] flags_o
);
  logic [FLAG_W-1:0] flags_q;
  logic [FLAG_W-1:0] flags_d;
  logic [FLAG_W-1:0] work;

  always_comb begin
    work = flags_q;
    if (load_i) begin
      work = load_data_i;
    end else begin
      unique case (cmd_i)
        CMD_CLR_C: work[POS_CARRY] = 1'b0;
        CMD_SET_C: work[POS_CARRY] = 1'b1;
        CMD_TGL_C: work[POS_CARRY] = ~flags_q[POS_CARRY];
        CMD_CLR_I: work[POS_INTEN] = 1'b0;
        CMD_SET_I: work[POS_INTEN] = 1'b1;
        CMD_CLR_D: work[POS_DIR]   = 1'b0;
        CMD_SET_D: work[POS_DIR]   = 1'b1;
        default:   ;
      endcase
      if (status_upd_i) begin
        work[POS_CARRY] = status_i.carry;
        work[POS_PAR]   = status_i.parity;
        work[POS_AUX]   = status_i.aux;
        work[POS_ZERO]  = status_i.zero;
        work[POS_SIGN]  = status_i.sign;
        work[POS_OVF]   = status_i.ovf;
      end
    end
    flags_d = fix_word(work);
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) flags_q <= RESET_WORD;
    else         flags_q <= flags_d;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/psw_cond_eval.sv
module psw_cond_eval
  import psw_pkg::*;
(
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [COND_W-1:0] cond_i,
  input  logic              count_sel_i,
  input  logic              count_zero_i,
  output logic              take_o
);
  logic c, p, z, s, o, lt;
  logic [NUM_BASE-1:0] base;

  assign c  = flags_i[POS_CARRY];
  assign p  = flags_i[POS_PAR];
  assign z  = flags_i[POS_ZERO];
  assign s  = flags_i[POS_SIGN];
  assign o  = flags_i[POS_OVF];
  assign lt = s ^ o;

  // base tests indexed by cond[3:1]; cond[0] inverts
  assign base[0] = o;
  assign base[1] = c;
  assign base[2] = z;
  assign base[3] = c | z;
  assign base[4] = s;
  assign base[5] = p;
  assign base[6] = lt;
  assign base[7] = lt | z;

  logic sel_base;
  assign sel_base = base[cond_i[COND_W-1:1]];

  always_comb begin
    if (count_sel_i) take_o = count_zero_i;
    else             take_o = sel_base ^ cond_i[0];
  end
endmodule

// File: rtl/psw_branch_unit.sv
module psw_branch_unit
  import psw_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] result_i,
  input  logic              carry_i,
  input  logic              aux_i,
  input  logic              ovf_i,
  input  logic              word_i,
  input  logic              status_upd_i,
  input  logic [2:0]        ctl_cmd_i,
  input  logic              load_i,
  input  logic [15:0]       load_data_i,
  input  logic [3:0]        cond_i,
  input  logic              count_sel_i,
  input  logic              count_zero_i,
  output logic [15:0]       flags_o,
  output logic              take_o
);
  status_t  status_w;
  ctl_cmd_e cmd_w;

  assign cmd_w = ctl_cmd_e'(ctl_cmd_i);

  psw_status_calc #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_calc (
    .result_i (result_i),
    .carry_i  (carry_i),
    .aux_i    (aux_i),
    .ovf_i    (ovf_i),
    .word_i   (word_i),
    .status_o (status_w)
  );

  psw_word_reg u_reg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (load_i),
    .load_data_i  (load_data_i),
    .status_upd_i (status_upd_i),
    .status_i     (status_w),
    .cmd_i        (cmd_w),
    .flags_o      (flags_o)
  );

  psw_cond_eval u_eval (
    .flags_i      (flags_o),
    .cond_i       (cond_i),
    .count_sel_i  (count_sel_i),
    .count_zero_i (count_zero_i),
    .take_o       (take_o)
  );
endmodule

// File: rtl/psw_branch_chk.sv
module psw_branch_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] result_i,
  input logic        carry_i,
  input logic        aux_i,
  input logic        ovf_i,
  input logic        status_upd_i,
  input logic [2:0]  ctl_cmd_i,
  input logic        load_i,
  input logic [15:0] load_data_i,
  input logic [3:0]  cond_i,
  input logic        count_sel_i,
  input logic        count_zero_i,
  input logic [15:0] flags_o,
  input logic        take_o
);
  AST_FIXED_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[1] && !flags_o[3] && !flags_o[5] && (flags_o[15:12] == 4'h0)); // R2

  AST_LOAD_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (flags_o == (($past(load_data_i) & 16'h0FD5) | 16'h0002))); // R3

  AST_STATUS_SIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_upd_i && !load_i) |=> (flags_o[0] == $past(carry_i)) &&
      (flags_o[4] == $past(aux_i)) && (flags_o[11] == $past(ovf_i))); // R4

  AST_PARITY_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_upd_i && !load_i) |=> (flags_o[2] == ~(^$past(result_i[7:0])))); // R5

  AST_TRAP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(flags_o[8])); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !status_upd_i && (ctl_cmd_i == 3'd0)) |=> $stable(flags_o)); // R9

  AST_COUNT_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_sel_i |-> (take_o == count_zero_i)); // R12

  AST_EQUAL_TEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!count_sel_i && (cond_i == 4'd4)) |-> (take_o == flags_o[6])); // R13
endmodule

bind psw_branch_unit psw_branch_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .result_i     (result_i),
  .carry_i      (carry_i),
  .aux_i        (aux_i),
  .ovf_i        (ovf_i),
  .status_upd_i (status_upd_i),
  .ctl_cmd_i    (ctl_cmd_i),
  .load_i       (load_i),
  .load_data_i  (load_data_i),
  .cond_i       (cond_i),
  .count_sel_i  (count_sel_i),
  .count_zero_i (count_zero_i),
  .flags_o      (flags_o),
  .take_o       (take_o)
);

// File: tb/psw_branch_unit_tb_top.sv
module psw_branch_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] result = '0;
  logic        carry = 1'b0, aux = 1'b0, ovf = 1'b0, word = 1'b1;
  logic        upd = 1'b0;
  logic [2:0]  cmd = 3'd0;
  logic        load = 1'b0;
  logic [15:0] load_data = '0;
  logic [3:0]  cond = '0;
  logic        csel = 1'b0, czero = 1'b0;
  logic [15:0] flags;
  logic        take;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  psw_branch_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .result_i(result), .carry_i(carry),
    .aux_i(aux), .ovf_i(ovf), .word_i(word), .status_upd_i(upd),
    .ctl_cmd_i(cmd), .load_i(load), .load_data_i(load_data),
    .cond_i(cond), .count_sel_i(csel), .count_zero_i(czero),
    .flags_o(flags), .take_o(take)
  );

  typedef struct {
    logic [15:0] exp_flags;
    logic        exp_take;
    string       tag;
  } item_t;

  item_t       sb[$];
  logic [15:0] model = 16'h0002;

  function automatic logic [15:0] next_word(
      input logic [15:0] cur, input logic ld, input logic [15:0] ldat,
      input logic up, input logic [15:0] r, input logic c, input logic a,
      input logic o, input logic w, input logic [2:0] k);
    logic [15:0] n;
    n = cur;
    if (ld) n = ldat;
    else begin
      case (k)
        3'd1: n[0] = 1'b0;
        3'd2: n[0] = 1'b1;
        3'd3: n[0] = ~cur[0];
        3'd4: n[9] = 1'b0;
        3'd5: n[9] = 1'b1;
        3'd6: n[10] = 1'b0;
        3'd7: n[10] = 1'b1;
        default: ;
      endcase
      if (up) begin
        n[0]  = c;
        n[4]  = a;
        n[11] = o;
        n[2]  = ($countones(r[7:0]) % 2) == 0;
        n[6]  = w ? (r == 16'h0) : (r[7:0] == 8'h0);
        n[7]  = w ? r[15] : r[7];
      end
    end
    n[1] = 1'b1; n[3] = 1'b0; n[5] = 1'b0; n[15:12] = 4'h0;
    return n;
  endfunction

  function automatic logic branch(input logic [15:0] f, input logic [3:0] cc,
                                  input logic cs, input logic cz);
    logic cf, pf, zf, sf, of, t;
    cf = f[0]; pf = f[2]; zf = f[6]; sf = f[7]; of = f[11];
    if (cs) return cz;
    case (cc)
      4'd0:  t = of;
      4'd1:  t = !of;
      4'd2:  t = cf;
      4'd3:  t = !cf;
      4'd4:  t = zf;
      4'd5:  t = !zf;
      4'd6:  t = cf || zf;
      4'd7:  t = !cf && !zf;
      4'd8:  t = sf;
      4'd9:  t = !sf;
      4'd10: t = pf;
      4'd11: t = !pf;
      4'd12: t = sf != of;
      4'd13: t = sf == of;
      4'd14: t = (sf != of) || zf;
      default: t = !zf && (sf == of);
    endcase
    return t;
  endfunction

  // driver: applies one cycle of stimulus and queues the expectation
  task automatic step(input string tag, input logic ld, input logic [15:0] ldat,
                      input logic up, input logic [15:0] r, input logic c,
                      input logic a, input logic o, input logic w,
                      input logic [2:0] k, input logic [3:0] cc,
                      input logic cs, input logic cz);
    item_t it;
    @(negedge clk);
    load = ld; load_data = ldat; upd = up; result = r; carry = c;
    aux = a; ovf = o; word = w; cmd = k; cond = cc; csel = cs; czero = cz;
    model = next_word(model, ld, ldat, up, r, c, a, o, w, k);
    it.exp_flags = model;
    it.exp_take  = branch(model, cc, cs, cz);
    it.tag       = tag;
    sb.push_back(it);
  endtask

  task automatic idle(input string tag, input logic [3:0] cc,
                      input logic cs, input logic cz);
    step(tag, 1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, cc, cs, cz);
  endtask

  // monitor: one edge after each stimulus, compare word and decision
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (flags !== it.exp_flags) begin
        errors++;
        $display("FAIL %s flags got %h expected %h", it.tag, flags, it.exp_flags);
      end
      checks++;
      if (take !== it.exp_take) begin
        errors++;
        $display("FAIL %s take got %b expected %b", it.tag, take, it.exp_take);
      end
    end
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    checks++;
    if (flags !== 16'h0002) begin
      errors++;
      $display("FAIL R1 reset flags got %h expected %h", flags, 16'h0002);
    end

    // R2 R3: load all ones, then all zeros, with equal/not-equal tests
    step("R2_R3_load_ones", 1'b1, 16'hFFFF, 1'b0, 16'h0, 0, 0, 0, 1, 3'd0, 4'd4, 0, 0);
    step("R2_R3_load_zero", 1'b1, 16'h0000, 1'b0, 16'h0, 0, 0, 0, 1, 3'd0, 4'd5, 0, 0);
    step("R3_load_pattern", 1'b1, 16'hA5A5, 1'b0, 16'h0, 0, 0, 0, 1, 3'd0, 4'd0, 0, 0);
    // R3 priority over update and command
    step("R3_load_priority", 1'b1, 16'h0100, 1'b1, 16'hFFFF, 1, 1, 1, 1, 3'd5, 4'd2, 0, 0);

    // R4 R5 R6 word updates
    step("R4_R5_R6_word_zero", 0, 16'h0, 1, 16'h0000, 1, 0, 0, 1, 3'd0, 4'd6, 0, 0);
    step("R4_R5_R6_word_neg", 0, 16'h0, 1, 16'h8001, 0, 1, 1, 1, 3'd0, 4'd12, 0, 0);
    step("R5_R6_word_hi_only", 0, 16'h0, 1, 16'h0300, 0, 0, 0, 1, 3'd0, 4'd10, 0, 0);
    // R6 byte updates
    step("R6_byte_zero_low", 0, 16'h0, 1, 16'h0100, 0, 0, 0, 0, 3'd0, 4'd4, 0, 0);
    step("R6_byte_sign", 0, 16'h0, 1, 16'h0080, 1, 0, 0, 0, 3'd0, 4'd8, 0, 0);
    step("R5_byte_odd", 0, 16'h0, 1, 16'h7F07, 0, 1, 1, 0, 3'd0, 4'd11, 0, 0);

    // R7 commands
    step("R7_set_carry", 0, 16'h0, 0, 16'h0, 0, 0, 0, 1, 3'd2, 4'd2, 0, 0);
    step("R7_toggle_carry", 0, 16'h0, 0, 16'h0, 0, 0, 0, 1, 3'd3, 4'd3, 0, 0);
    step("R7_toggle_again", 0, 16'h0, 0, 16'h0, 0, 0, 0, 1, 3'd3, 4'd2, 0, 0);
    step("R7_clr_carry", 0, 16'h0, 0, 16'h0, 0, 0, 0, 1, 3'd1, 4'd7, 0, 0);
    step("R7_set_int", 0, 16'h0, 0, 16'h0, 0, 0, 0, 1, 3'd5, 4'd0, 0, 0);
    step("R7_set_dir", 0, 16'h0, 0, 16'h0, 0, 0, 0, 1, 3'd7, 4'd0, 0, 0);
    step("R7_clr_int", 0, 16'h0, 0, 16'h0, 0, 0, 0, 1, 3'd4, 4'd0, 0, 0);
    step("R7_clr_dir", 0, 16'h0, 0, 16'h0, 0, 0, 0, 1, 3'd6, 4'd0, 0, 0);

    // R8 update together with commands
    step("R8_upd_beats_setc", 0, 16'h0, 1, 16'h0001, 0, 0, 0, 1, 3'd2, 4'd2, 0, 0);
    step("R8_upd_beats_tglc", 0, 16'h0, 1, 16'h0001, 1, 0, 0, 1, 3'd3, 4'd2, 0, 0);
    step("R8_upd_with_seti", 0, 16'h0, 1, 16'h00FF, 0, 0, 0, 0, 3'd5, 4'd10, 0, 0);
    step("R8_upd_with_setd", 0, 16'h0, 1, 16'h8000, 0, 0, 1, 1, 3'd7, 4'd13, 0, 0);

    // R9 hold
    idle("R9_hold_a", 4'd14, 0, 0);
    idle("R9_hold_b", 4'd15, 0, 0);

    // R10 R11 R13 sweep over several loaded patterns
    for (int pat = 0; pat < 4; pat++) begin
      logic [15:0] pw;
      case (pat)
        0: pw = 16'h0000;
        1: pw = 16'h0FD5;
        2: pw = 16'h0880;
        default: pw = 16'h0045;
      endcase
      step("R3_sweep_load", 1'b1, pw, 0, 16'h0, 0, 0, 0, 1, 3'd0, 4'd0, 0, 0);
      for (int cc = 0; cc < 16; cc++) begin
        if (cc < 8) idle("R10_R13_cond", 4'(cc), 0, 0);
        else        idle("R11_R13_cond", 4'(cc), 0, 0);
      end
    end

    // R12 count select
    idle("R12_count_zero", 4'd4, 1, 1);
    idle("R12_count_nonzero", 4'd5, 1, 0);
    idle("R12_count_zero_b", 4'd0, 1, 1);

    idle("R9_final", 4'd0, 0, 0);
    @(negedge clk);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule